// File: doc/BRIEF.md
# Precomputed SDRAM Command Replay Engine

This block plays back an SDRAM command stream that was worked out before run time and written into an on-chip schedule memory. It does not accept requests and it does not arbitrate. A program counter walks the schedule memory one word at a time. Each word is unpacked into a command code, a bank number and a row/column address, and these are presented to the PHY. A small wait counter then holds the engine idle for the number of cycles that the word itself specifies. After that the next word is played.

The schedule memory has one cycle of read latency. The engine hides it by fetching the following word in the same cycle that it plays the current one, so a zero wait gives back-to-back commands. A dedicated end code stops the playback and raises a sticky completion flag. An enable input pauses the engine: while it is low, no state is lost and no command is emitted. The memory load port lets a host, or the testbench, write schedule words before the run starts.

Top module: `cmd_replay`

## Requirements
- R1: While reset is applied and just after it, cmd_vld and done are 0 and cmd_op, cmd_bank and cmd_addr are all 0.
- R2: A schedule word packs the command code in bits 23:21, the bank in bits 20:18, the address in bits 17:4 and the wait count in bits 3:0. A played command shows exactly those fields on cmd_op, cmd_bank and cmd_addr.
- R3: After reset with en held high, the command in slot 0 appears on the outputs after the second rising edge with en high. The first enabled edge fetches the word and the second plays it.
- R4: If a slot with wait count d is played at enabled edge n, the next slot is played at enabled edge n+d+1. A wait count of 0 therefore gives back-to-back commands.
- R5: Codes 1 (activate), 2 (read), 3 (write) and 4 (precharge) raise cmd_vld for exactly one cycle. At every other time cmd_vld is 0 and cmd_op, cmd_bank and cmd_addr read 0, with 0 meaning no operation.
- R6: A slot with code 0, 6 or 7 emits no strobe. It still consumes its wait count before the next slot is played.
- R7: Code 5 (end of schedule) emits no strobe. It sets done after the edge at which it is reached. done then stays high, and no further command is emitted until reset.
- R8: While en is low at a rising edge, the wait counter and the program counter hold their values and cmd_vld is 0 after that edge. Playback resumes with the same timing counted in enabled edges.
- R9: Applying reset in the middle of a run returns playback to slot 0, with the same start-up timing as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low pauses playback |
| ld_we | input | 1 | Schedule memory write strobe |
| ld_addr | input | ADDR_W | Schedule memory write address |
| ld_data | input | 24 | Schedule word to write |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command code of the played word |
| cmd_bank | output | 3 | Bank of the played word |
| cmd_addr | output | 14 | Row/column address of the played word |
| done | output | 1 | End of schedule reached |

## Verification
A corrupted wait counter or program counter shows up at the ports as a command strobe on the wrong enabled edge, or with another slot's fields. This is caught at the first command after the fault, no later than 16 enabled cycles. A bad prefetch shows up as a slot played twice or skipped, and a scoreboard that compares both the arrival edge and the fields of every command catches it. A wrong enable or end-of-schedule path shows up as a strobe during a pause or after done. Assertions catch it on that very cycle.

// File: rtl/cmd_replay_pkg.sv
package cmd_replay_pkg;
  localparam int WORD_W = 24;
  localparam int OP_W   = 3;
  localparam int BANK_W = 3;
  localparam int ADR_W  = 14;
  localparam int DLY_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_END = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } op_e;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [BANK_W-1:0] bank;
    logic [ADR_W-1:0]  addr;
    logic [DLY_W-1:0]  dly;
  } sched_word_t;

  function automatic logic is_issuable(input logic [OP_W-1:0] op);
    return (op == OP_ACT) || (op == OP_RD) || (op == OP_WR) || (op == OP_PRE);
  endfunction
endpackage

// File: rtl/cmd_replay_mem.sv
module cmd_replay_mem
  import cmd_replay_pkg::*;
#(
  parameter int DEPTH  = 1536,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/cmd_replay_wait.sv
module cmd_replay_wait #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = load_val;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ce)  cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cmd_replay_out.sv
module cmd_replay_out
  import cmd_replay_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  sched_word_t       word,
  output logic              cmd_vld,
  output logic [OP_W-1:0]   cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADR_W-1:0]  cmd_addr
);
  logic              vld_d;
  logic [OP_W-1:0]   op_d;
  logic [BANK_W-1:0] bank_d;
  logic [ADR_W-1:0]  addr_d;

  always_comb begin
    vld_d  = fire;
    op_d   = '0;
    bank_d = '0;
    addr_d = '0;
    if (fire) begin
      op_d   = word.op;
      bank_d = word.bank;
      addr_d = word.addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd_op   <= '0;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else begin
      cmd_vld  <= vld_d;
      cmd_op   <= op_d;
      cmd_bank <= bank_d;
      cmd_addr <= addr_d;
    end
  end
endmodule

// File: rtl/cmd_replay.sv
module cmd_replay
  import cmd_replay_pkg::*;
#(
  parameter int DEPTH  = 1536,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [23:0]       ld_data,
  output logic              cmd_vld,
  output logic [2:0]        cmd_op,
  output logic [2:0]        cmd_bank,
  output logic [13:0]       cmd_addr,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              primed_q, primed_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] mem_q;
  sched_word_t       cur;
  logic              wait_done, slot_go, is_end, at_last, advance, more;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;

  assign cur = sched_word_t'(mem_q);

  cmd_replay_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .wr_en(ld_we), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(mem_q)
  );

  always_comb begin
    slot_go = en && primed_q && !done_q && wait_done;
    is_end  = (cur.op == OP_END);
    at_last = (pc_q == LAST_SLOT);
    advance = slot_go && !is_end;
    more    = advance && !at_last;
    rd_en   = en && !done_q && (!primed_q || more);
    rd_addr = primed_q ? pc_q + 1'b1 : pc_q;
    pc_d     = more ? pc_q + 1'b1 : pc_q;
    primed_d = primed_q || (en && !done_q);
    done_d   = done_q || (slot_go && (is_end || at_last));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      primed_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (en) begin
      pc_q     <= pc_d;
      primed_q <= primed_d;
      done_q   <= done_d;
    end
  end

  cmd_replay_wait #(.CNT_W(DLY_W)) wait_i (
    .clk(clk), .rst_n(rst_n), .ce(en), .load(advance),
    .load_val(cur.dly), .expired(wait_done)
  );

  cmd_replay_out out_i (
    .clk(clk), .rst_n(rst_n), .fire(advance && is_issuable(cur.op)),
    .word(cur), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  assign done = done_q;
endmodule

// File: rtl/cmd_replay_chk.sv
module cmd_replay_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cmd_vld,
  input logic [2:0]        cmd_op,
  input logic [2:0]        cmd_bank,
  input logic [13:0]       cmd_addr,
  input logic              done,
  input logic [ADDR_W-1:0] pc_q
);
  p_strobe_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (cmd_op >= 3'd1 && cmd_op <= 3'd4));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |-> (cmd_op == 3'd0 && cmd_bank == 3'd0 && cmd_addr == 14'd0));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_done_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_vld);
  p_pause_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cmd_vld);
  p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_q));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (!cmd_vld && !done));
endmodule

bind cmd_replay cmd_replay_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .done(done), .pc_q(pc_q)
);

// File: tb/cmd_replay_tb_top.sv
module cmd_replay_tb_top;
  localparam int DEPTH  = 1536;
  localparam int ADDR_W = $clog2(DEPTH);

  typedef struct {
    int         t;
    logic [2:0] op;
    logic [2:0] bank;
    logic [13:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ld_we = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [23:0] ld_data = '0;
  logic cmd_vld, done;
  logic [2:0] cmd_op, cmd_bank;
  logic [13:0] cmd_addr;

  int n_run = 0, n_fail = 0;
  int tick = 0, cyc = 0;
  int exp_done = -1;
  bit mon_on = 1'b0;
  bit en_at_edge = 1'b0;
  bit toggle_en = 1'b0;
  exp_t q[$];
  logic [23:0] prog [16];
  int prog_len = 0;

  always #2.5 clk = ~clk;

  cmd_replay #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .done(done)
  );

  function automatic logic [23:0] pack(input int op, input int bank, input int addr, input int dly);
    return {3'(op), 3'(bank), 14'(addr), 4'(dly)};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, act, expv, tick);
    end
  endtask

  // driver: load the program and push the expected commands into the scoreboard
  task automatic load_and_plan();
    int t;
    for (int k = 0; k < prog_len; k++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = ADDR_W'(k); ld_data = prog[k];
    end
    @(negedge clk);
    ld_we = 1'b0;
    q.delete();
    exp_done = -1;
    t = 2;
    for (int k = 0; k < prog_len; k++) begin
      int op;
      op = int'(prog[k][23:21]);
      if (op == 5) begin exp_done = t; break; end
      if (op >= 1 && op <= 4) begin
        exp_t e;
        e.t = t; e.op = prog[k][23:21]; e.bank = prog[k][20:18]; e.addr = prog[k][17:4];
        q.push_back(e);
      end
      t = t + int'(prog[k][3:0]) + 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_vld == 1'b0 && done == 1'b0, "R1", "strobe/done in reset", int'({cmd_vld, done}), 0);
    check(cmd_op == 3'd0 && cmd_bank == 3'd0 && cmd_addr == 14'd0, "R1", "fields in reset",
          int'({cmd_op, cmd_bank, cmd_addr}), 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin tick <= 0; en_at_edge <= 1'b0; end
    else begin
      en_at_edge <= en;
      if (en) tick <= tick + 1;
    end
  end

  // enable pattern driven away from the edge
  always @(negedge clk) begin
    cyc++;
    if (toggle_en && rst_n) en = ((cyc % 3) != 0);
  end

  // monitor: pops expected commands and compares arrival edge and fields
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (!en_at_edge && cmd_vld)
        check(1'b0, "R8", "strobe after paused edge", 1, 0);
      if (cmd_vld) begin
        if (q.size() == 0) check(1'b0, "R7", "unexpected strobe", int'(cmd_op), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(tick == e.t, "R4", "strobe edge", tick, e.t);
          check(cmd_op == e.op && cmd_bank == e.bank && cmd_addr == e.addr, "R2", "fields",
                int'({cmd_op, cmd_bank, cmd_addr}), int'({e.op, e.bank, e.addr}));
        end
      end else if (cmd_op != 3'd0 || cmd_bank != 3'd0 || cmd_addr != 14'd0)
        check(1'b0, "R5", "idle fields not zero", int'({cmd_op, cmd_bank, cmd_addr}), 0);
      if (done != (exp_done >= 0 && tick >= exp_done))
        check(1'b0, "R7", "done level", int'(done), int'(exp_done >= 0 && tick >= exp_done));
    end
  end

  task automatic run_to_done(input string req);
    int guard;
    guard = 0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    check(done == 1'b1, req, "done reached", int'(done), 1);
    check(tick == exp_done, "R7", "done edge", tick, exp_done);
    repeat (40) @(negedge clk);
    check(q.size() == 0, req, "commands left unplayed", q.size(), 0);
    check(done == 1'b1, "R7", "done sticky", int'(done), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // program A: waits 3, 0, 0, 2, 15, 1, 1; nop and reserved slots; end slot with nonzero fields
    prog[0] = pack(1, 1, 14'h1234, 3);
    prog[1] = pack(2, 1, 14'h0040, 0);
    prog[2] = pack(2, 1, 14'h0048, 0);
    prog[3] = pack(0, 5, 14'h3FFF, 2);
    prog[4] = pack(3, 2, 14'h2001, 15);
    prog[5] = pack(7, 3, 14'h0AAA, 1);
    prog[6] = pack(4, 7, 14'h0400, 1);
    prog[7] = pack(5, 6, 14'h1555, 0);
    prog[8] = pack(2, 0, 14'h0001, 0);
    prog_len = 9;

    do_reset();
    load_and_plan();
    mon_on = 1'b1;
    // R8: paused after reset, nothing emitted
    repeat (10) @(negedge clk);
    check(cmd_vld == 1'b0 && tick == 0, "R8", "idle while paused", int'(cmd_vld), 0);
    en = 1'b1;
    @(negedge clk);
    check(cmd_vld == 1'b0, "R3", "no strobe after fetch edge", int'(cmd_vld), 0);
    @(negedge clk);
    check(cmd_vld == 1'b1 && cmd_op == 3'd1, "R3", "slot 0 after second edge", int'(cmd_op), 1);
    run_to_done("R6");

    // R8: replay with enable toggling, timing counted in enabled edges
    mon_on = 1'b0;
    do_reset();
    load_and_plan();
    mon_on = 1'b1;
    toggle_en = 1'b1;
    run_to_done("R8");
    toggle_en = 1'b0;

    // R9: reset part way through, then the whole schedule from slot 0
    mon_on = 1'b0;
    do_reset();
    load_and_plan();
    mon_on = 1'b1;
    en = 1'b1;
    repeat (9) @(negedge clk);
    mon_on = 1'b0;
    do_reset();
    q.delete();
    load_and_plan();
    mon_on = 1'b1;
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_vld == 1'b1 && cmd_addr == 14'h1234, "R9", "restart at slot 0", int'(cmd_addr), 'h1234);
    run_to_done("R9");

    // program B: back-to-back commands with zero waits
    prog[0] = pack(1, 0, 14'h0011, 0);
    prog[1] = pack(1, 4, 14'h0022, 0);
    prog[2] = pack(2, 0, 14'h0033, 0);
    prog[3] = pack(3, 4, 14'h0044, 0);
    prog[4] = pack(4, 0, 14'h0055, 0);
    prog[5] = pack(5, 0, 14'h0000, 0);
    prog_len = 6;
    mon_on = 1'b0;
    do_reset();
    load_and_plan();
    mon_on = 1'b1;
    en = 1'b1;
    run_to_done("R4");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule